// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a bus-programmable watchdog built around a 32-bit down-counter. While the run bit is set, the counter steps down once per clock. When it reaches zero it raises an interrupt and starts again from the programmed load value. If software has not cleared the interrupt by the time the counter reaches zero a second time, the block asserts a reset request, provided the reset-enable bit is set. The reset request stays asserted until the block itself is reset.

Software reaches the block through a simple APB-style slave port with zero wait states. The port has registers for the load value, the live count, control, interrupt clear, raw status and masked status. A key register guards every other register: writes to the other registers take effect only while the block is unlocked. Writing the 32-bit key to the key register unlocks the block, and writing any other value locks it again. A write takes effect on the clock edge where `psel`, `penable` and `pwrite` are all high. Read data is combinational from `paddr`. The port has no back-pressure, and every access completes in its access phase.

Top module: `twostage_wdog`

## Requirements
- R1: After reset the block is unlocked and control reads 0. Load and value both read 0xFFFFFFFF. `irq_o` and `rst_req_o` are low.
- R2: While control bit 0 (run) is 1, the count at offset 0x004 decreases by one per clock down to 0. On the following clock it is reloaded, so one period is load+1 clocks. While run is 0 and no reload write occurs, the count holds.
- R3: When the count is 0 and run is 1, the next clock sets bit 0 of raw status (offset 0x010) and reloads the count from the load register.
- R4: If an expiry occurs while raw status bit 0 is already 1, `rst_req_o` rises on that same clock, provided control bit 1 (reset enable) is 1. It never rises while control bit 1 is 0.
- R5: Once high, `rst_req_o` stays high until `rst_n` is asserted. Register writes do not lower it.
- R6: Bit 0 of masked status (offset 0x014) equals raw status bit 0 AND control bit 0. `irq_o` equals that masked bit.
- R7: Any write to offset 0x00C, whatever its data, clears raw status bit 0 and reloads the count from the load register.
- R8: A write to offset 0x000 stores the data as the load value and also loads it into the count. A data value of 0 is stored as 1.
- R9: Writing 0x1ACCE551 to offset 0xC00 unlocks the block, and writing any other value locks it. Reading 0xC00 returns 1 when locked and 0 when unlocked.
- R10: While locked, writes to offsets 0x000, 0x008 and 0x00C change neither a register, the count nor the status.
- R11: Reads of offsets other than 0x000, 0x004, 0x008, 0x010, 0x014 and 0xC00 return 0. Control reads back with bit 0 = run and bit 1 = reset enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational from paddr |
| irq_o | output | 1 | Level interrupt, equal to the masked status bit |
| rst_req_o | output | 1 | Sticky reset request |

## Verification
The embedded assertions check on every cycle the counter behaviour:
- the count steps down by one while running and holds while stopped;
- the raw interrupt rises only from an expiry;
- the reset request rises only while an interrupt is pending and reset is enabled, and never falls;
- the lock blocks writes to load and control;
- the load value is never zero.

The bench sweeps small load values with the reset enable both off and on. It checks the count on every cycle against arithmetic from the period load+1. This shows that the interrupt and the reset request appear on the exact cycle.

The key protocol, the clamp on a zero load, the clearing by any data and the masking when run is cleared appear only through these directed bench scenarios.

// File: rtl/twostage_wdog_pkg.sv
package twostage_wdog_pkg;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFF_LOAD = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_VAL  = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_ICLR = 12'h00C;
  localparam logic [ADDR_W-1:0] OFF_RIS  = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_MIS  = 12'h014;
  localparam logic [ADDR_W-1:0] OFF_KEY  = 12'hC00;

  typedef struct packed {
    logic rst_en;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import twostage_wdog_pkg::*;
#(
  parameter int DW = 32,
  parameter logic [DW-1:0] KEY = 32'h1ACCE551
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DW-1:0]     pwdata,
  output ctrl_t             ctrl_o,
  output logic [DW-1:0]     load_o,
  output logic              reload_o,
  output logic [DW-1:0]     reload_val_o,
  output logic              clr_o,
  output logic              locked_o
);
  localparam logic [DW-1:0] ONE  = {{(DW-1){1'b0}}, 1'b1};
  localparam logic [DW-1:0] ONES = '1;

  logic          wr, wr_ok;
  logic [DW-1:0] load_wdata;
  ctrl_t         ctrl_q;
  logic [DW-1:0] load_q;
  logic          locked_q;

  assign wr         = psel & penable & pwrite;
  assign wr_ok      = wr & ~locked_q;
  assign load_wdata = (pwdata == '0) ? ONE : pwdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      load_q   <= ONES;
      locked_q <= 1'b0;
    end else begin
      if (wr && paddr == OFF_KEY) locked_q <= (pwdata != KEY);
      if (wr_ok && paddr == OFF_CTRL) begin
        ctrl_q.run    <= pwdata[0];
        ctrl_q.rst_en <= pwdata[1];
      end
      if (wr_ok && paddr == OFF_LOAD) load_q <= load_wdata;
    end
  end

  assign reload_o     = wr_ok & ((paddr == OFF_LOAD) | (paddr == OFF_ICLR));
  assign reload_val_o = (paddr == OFF_LOAD) ? load_wdata : load_q;
  assign clr_o        = wr_ok & (paddr == OFF_ICLR);
  assign ctrl_o       = ctrl_q;
  assign load_o       = load_q;
  assign locked_o     = locked_q;

  // R10: a locked bank ignores control and load writes
  a_r10_ctrl_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && wr && paddr == OFF_CTRL) |=> $stable(ctrl_q));
  a_r10_load_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && wr && paddr == OFF_LOAD) |=> $stable(load_q));
  // R9: the key always unlocks, whatever the prior state
  a_r9_key_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr == OFF_KEY && pwdata == KEY) |=> !locked_q);
  // R8: the stored load value is never zero
  a_r8_load_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    load_q != '0);
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import twostage_wdog_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctrl_t         ctrl_i,
  input  logic [DW-1:0] load_i,
  input  logic          reload_i,
  input  logic [DW-1:0] reload_val_i,
  input  logic          clr_i,
  output logic [DW-1:0] cnt_o,
  output logic          raw_o,
  output logic          rst_req_o
);
  logic [DW-1:0] cnt_q;
  logic          raw_q, rst_q;
  logic          at_zero;

  assign at_zero = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
      raw_q <= 1'b0;
      rst_q <= 1'b0;
    end else if (reload_i) begin
      cnt_q <= reload_val_i;
      if (clr_i) raw_q <= 1'b0;
    end else if (ctrl_i.run) begin
      if (at_zero) begin
        cnt_q <= load_i;
        raw_q <= 1'b1;
        if (raw_q && ctrl_i.rst_en) rst_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign cnt_o     = cnt_q;
  assign raw_o     = raw_q;
  assign rst_req_o = rst_q;

  // R2: one step per clock while running, no motion while stopped
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i.run && !reload_i && !at_zero) |=> cnt_q == $past(cnt_q) - 1'b1);
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_i.run && !reload_i) |=> $stable(cnt_q));
  // R3: the raw interrupt appears only from an expiry
  a_r3_raw_from_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_q) |-> $past(ctrl_i.run && at_zero));
  // R4: a reset request needs a pending interrupt and the enable
  a_r4_rst_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_q) |-> $past(raw_q && ctrl_i.rst_en));
  // R5: the reset request never falls outside reset
  a_r5_rst_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |=> rst_q);
endmodule

// File: rtl/wdog_rdata.sv
module wdog_rdata
  import twostage_wdog_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [ADDR_W-1:0] paddr,
  input  ctrl_t             ctrl_i,
  input  logic [DW-1:0]     load_i,
  input  logic [DW-1:0]     cnt_i,
  input  logic              raw_i,
  input  logic              locked_i,
  output logic [DW-1:0]     prdata
);
  always_comb begin
    prdata = '0;
    unique case (paddr)
      OFF_LOAD: prdata = load_i;
      OFF_VAL:  prdata = cnt_i;
      OFF_CTRL: prdata = {{(DW-2){1'b0}}, ctrl_i.rst_en, ctrl_i.run};
      OFF_RIS:  prdata = {{(DW-1){1'b0}}, raw_i};
      OFF_MIS:  prdata = {{(DW-1){1'b0}}, raw_i & ctrl_i.run};
      OFF_KEY:  prdata = {{(DW-1){1'b0}}, locked_i};
      default:  prdata = '0;
    endcase
  end
endmodule

// File: rtl/twostage_wdog.sv
module twostage_wdog
  import twostage_wdog_pkg::*;
#(
  parameter int DW = 32,
  parameter logic [DW-1:0] KEY = 32'h1ACCE551
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DW-1:0]     pwdata,
  output logic [DW-1:0]     prdata,
  output logic              irq_o,
  output logic              rst_req_o
);
  ctrl_t         ctrl;
  logic [DW-1:0] load_val, reload_val, cnt;
  logic          reload, clr, locked, raw;

  wdog_regs #(.DW(DW), .KEY(KEY)) u_regs (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .ctrl_o(ctrl), .load_o(load_val), .reload_o(reload),
    .reload_val_o(reload_val), .clr_o(clr), .locked_o(locked)
  );

  wdog_core #(.DW(DW)) u_core (
    .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl), .load_i(load_val),
    .reload_i(reload), .reload_val_i(reload_val), .clr_i(clr),
    .cnt_o(cnt), .raw_o(raw), .rst_req_o(rst_req_o)
  );

  wdog_rdata #(.DW(DW)) u_rdata (
    .paddr(paddr), .ctrl_i(ctrl), .load_i(load_val), .cnt_i(cnt),
    .raw_i(raw), .locked_i(locked), .prdata(prdata)
  );

  assign irq_o = raw & ctrl.run;
endmodule

// File: tb/twostage_wdog_tb.sv
module twostage_wdog_tb;
  import twostage_wdog_pkg::*;

  localparam logic [31:0] KEY = 32'h1ACCE551;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        irq_o, rst_req_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  twostage_wdog u_dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .prdata(prdata), .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    paddr = a;
    #2;
    d = prdata;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual %h expected %h", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    do_reset();
    // R1 reset state
    rd(OFF_KEY, d);  chk("R1 lock", d, 32'd0);
    rd(OFF_CTRL, d); chk("R1 ctrl", d, 32'd0);
    rd(OFF_LOAD, d); chk("R1 load", d, 32'hFFFFFFFF);
    rd(OFF_VAL, d);  chk("R1 value", d, 32'hFFFFFFFF);
    chk("R1 irq", 32'(irq_o), 32'd0);
    chk("R1 rst", 32'(rst_req_o), 32'd0);
    // R2 hold while stopped
    repeat (5) @(negedge clk);
    rd(OFF_VAL, d); chk("R2 hold", d, 32'hFFFFFFFF);

    // R2 R3 R4 R6 sweep over load and reset enable
    for (int L = 1; L <= 6; L++) begin
      for (int re = 0; re < 2; re++) begin
        do_reset();
        wr(OFF_LOAD, 32'(L));
        wr(OFF_CTRL, (re == 1) ? 32'd3 : 32'd1);
        for (int k = 0; k <= 2 * L + 4; k++) begin
          if (k > 0) @(negedge clk);
          rd(OFF_VAL, d); chk("R2 count", d, 32'(L - (k % (L + 1))));
          rd(OFF_RIS, d); chk("R3 raw", d, 32'(k >= L + 1));
          rd(OFF_MIS, d); chk("R6 masked", d, 32'(k >= L + 1));
          chk("R6 irq", 32'(irq_o), 32'(k >= L + 1));
          chk("R4 rst", 32'(rst_req_o), 32'(re == 1 && k >= 2 * L + 2));
        end
        if (re == 1) begin
          wr(OFF_ICLR, 32'd0);
          wr(OFF_CTRL, 32'd0);
          repeat (3) @(negedge clk);
          chk("R5 sticky", 32'(rst_req_o), 32'd1);
        end else begin
          // R6 masking when run cleared
          wr(OFF_CTRL, 32'd0);
          rd(OFF_RIS, d); chk("R6 raw kept", d, 32'd1);
          rd(OFF_MIS, d); chk("R6 masked off", d, 32'd0);
          chk("R6 irq off", 32'(irq_o), 32'd0);
        end
      end
    end

    // R9 R10 lock behaviour
    do_reset();
    wr(OFF_LOAD, 32'd5);
    wr(OFF_KEY, 32'd1);
    rd(OFF_KEY, d);  chk("R9 locked", d, 32'd1);
    wr(OFF_LOAD, 32'd9);
    rd(OFF_LOAD, d); chk("R10 load ignored", d, 32'd5);
    wr(OFF_CTRL, 32'd1);
    rd(OFF_CTRL, d); chk("R10 ctrl ignored", d, 32'd0);
    repeat (3) @(negedge clk);
    rd(OFF_VAL, d);  chk("R10 count idle", d, 32'd5);
    wr(OFF_KEY, KEY);
    rd(OFF_KEY, d);  chk("R9 unlocked", d, 32'd0);
    wr(OFF_LOAD, 32'd9);
    rd(OFF_LOAD, d); chk("R9 load written", d, 32'd9);
    rd(OFF_VAL, d);  chk("R8 reload on load", d, 32'd9);

    // R7 clear, also blocked while locked
    wr(OFF_LOAD, 32'd2);
    wr(OFF_CTRL, 32'd1);
    repeat (4) @(negedge clk);
    rd(OFF_RIS, d);  chk("R3 raw set", d, 32'd1);
    wr(OFF_CTRL, 32'd0);
    wr(OFF_KEY, 32'h1ACCE550);
    wr(OFF_ICLR, 32'd0);
    rd(OFF_RIS, d);  chk("R10 clear ignored", d, 32'd1);
    wr(OFF_KEY, KEY);
    wr(OFF_CTRL, 32'd1);
    wr(OFF_ICLR, 32'hDEADBEEF);
    rd(OFF_RIS, d);  chk("R7 cleared", d, 32'd0);
    rd(OFF_VAL, d);  chk("R7 reload", d, 32'd2);

    // R8 zero clamp
    wr(OFF_CTRL, 32'd0);
    wr(OFF_LOAD, 32'd0);
    rd(OFF_LOAD, d); chk("R8 clamp load", d, 32'd1);
    rd(OFF_VAL, d);  chk("R8 clamp count", d, 32'd1);

    // R11 read map
    wr(OFF_CTRL, 32'd2);
    rd(OFF_CTRL, d);  chk("R11 ctrl bits", d, 32'd2);
    rd(12'h018, d);   chk("R11 unmapped", d, 32'd0);
    rd(12'h800, d);   chk("R11 unmapped high", d, 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule